// File: doc/BRIEF.md
# Converter Start-Up and Fault Recovery Sequencer

This block decides, once per switching cycle, whether the power stage of a buck converter may switch. It runs the soft-start ramp and reports its progress as a count. It also tracks two fault conditions and drives recovery from each. Overcurrent goes into a saturating accumulator that rises faster than it falls. When the accumulator fills, switching stops for a short hold and then a fresh ramp begins. Overvoltage must persist for a number of consecutive cycles before it acts. It then stops switching until the output has sagged below the undervoltage level. After that, a set number of idle ramp periods pass with switching off before a normal ramp starts.

Every update is gated by a one-clock cycle tick from the converter oscillator, so the block runs on a fast system clock while counting switching cycles. The enable input overrides everything. The comparators, current sensing and gate drive sit outside the block. They deliver their results as level flags that are sampled on each tick.

Top module: `ss_fault_seq`

## Requirements
- R1: While reset is asserted, and on the clock edge after `en` is seen low, `pwm_en`, `ss_active` and `ss_ramp` are all 0.
- R2: With `en` high and the block idle, the next tick starts a soft-start: `pwm_en`=1, `ss_active`=1, `ss_ramp`=0. Each later tick raises `ss_ramp` by one.
- R3: After SS_CYCLES ticks of ramp (4096 by default), `ss_active` drops to 0. `pwm_en` stays 1 and `ss_ramp` holds SS_CYCLES-1.
- R4: A clock edge with `cyc_tick` low and `en` high changes no output.
- R5: On each tick with switching on, a high `oc_sample` adds 2 to a 4-bit accumulator, saturating at 15. A low one subtracts 1. When the accumulator reaches 15, `pwm_en` drops on that tick. Overcurrent on one tick in three never trips; overcurrent on every tick trips on the 8th.
- R6: The accumulator never goes below 0, so after a long run of clean ticks, 7 overcurrent ticks do not trip and the 8th does.
- R7: After an overcurrent trip, `pwm_en` stays 0 for 16 ticks. The 16th tick starts a new soft-start with `ss_ramp`=0.
- R8: The accumulator is empty at every new soft-start, so 7 overcurrent ticks right after a restart do not trip.
- R9: `ov_flag` high on 32 consecutive ticks with switching on drops `pwm_en`. Any tick with `ov_flag` low restarts that count, so runs of 31 never trip.
- R10: After an overvoltage trip, `pwm_en` stays 0 for as long as `uv_flag` is low, however many ticks pass.
- R11: The first tick with `uv_flag` high starts 2 × SS_CYCLES idle ticks with `pwm_en`=0. The last of them starts a normal soft-start.
- R12: If the overvoltage and overcurrent trips happen on the same tick, the overvoltage recovery (R10, R11) is taken.
- R13: `en` low forces shutdown on the next clock edge, with or without a tick. Raising `en` again gives a fresh soft-start from `ss_ramp`=0 on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| en | input | 1 | Converter enable, high to run |
| oc_sample | input | 1 | Overcurrent result for the ending cycle |
| ov_flag | input | 1 | Output above the overvoltage limit |
| uv_flag | input | 1 | Output below the undervoltage limit |
| pwm_en | output | 1 | Power stage may switch |
| ss_active | output | 1 | Soft-start ramp in progress |
| ss_ramp | output | 12 | Ramp position, 0 while switching is off |

## Verification
A corrupted accumulator or persistence count shows up only as a trip that comes a tick early or late, or one that never comes. The bench therefore runs threshold patterns that sit exactly one tick on either side of each limit. A wrong recovery state shows up as `pwm_en` rising after 16 ticks instead of waiting for `uv_flag`, or as an idle period of the wrong length. Each of these shows up within a few ticks of the event or at the end of the idle window. A reference model is compared with the outputs on every clock, so any divergence is reported in the cycle it appears.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic [2:0] {
    SQ_OFF      = 3'd0,
    SQ_RAMP     = 3'd1,
    SQ_RUN      = 3'd2,
    SQ_OC_HOLD  = 3'd3,
    SQ_OV_WAIT  = 3'd4,
    SQ_OV_DUMMY = 3'd5
  } sq_state_t;
endpackage

// File: rtl/ssf_oc_acc.sv
// Asymmetric saturating overcurrent accumulator.
module ssf_oc_acc #(
  parameter int ACC_W = 4,
  parameter int UP    = 2,
  parameter int DN    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clr,
  input  logic hit,
  output logic trip
);
  localparam int MAXV = (1 << ACC_W) - 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_q} + (ACC_W+1)'(UP);
    if (hit) begin
      if (sum > (ACC_W+1)'(MAXV)) acc_d = ACC_W'(MAXV);
      else                        acc_d = sum[ACC_W-1:0];
    end else begin
      if (acc_q < ACC_W'(DN))     acc_d = '0;
      else                        acc_d = acc_q - ACC_W'(DN);
    end
  end

  assign trip = step & hit & (acc_d == ACC_W'(MAXV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (clr)  acc_q <= '0;
    else if (step) acc_q <= acc_d;
  end
endmodule

// File: rtl/ssf_persist.sv
// Counts consecutive flagged ticks; fires on the LEN-th.
module ssf_persist #(
  parameter int LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clr,
  input  logic flag,
  output logic fire
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == CW'(LEN - 1));
  assign fire    = step & flag & at_last;

  always_comb begin
    if (!flag)        cnt_d = '0;
    else if (at_last) cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ssf_seq.sv
// Recovery state machine with ramp, hold and idle-period counters.
module ssf_seq
  import ssf_pkg::*;
#(
  parameter int SS_CYCLES  = 4096,
  parameter int HOLD_TICKS = 16,
  parameter int DUMMY_RUNS = 2,
  localparam int RW = $clog2(SS_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          oc_trip,
  input  logic          ov_fire,
  input  logic          uv,
  output logic          pwm_en,
  output logic          ss_active,
  output logic [RW-1:0] ramp
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int DW = $clog2(DUMMY_RUNS + 1);
  localparam logic [RW-1:0] RAMP_LAST  = RW'(SS_CYCLES - 1);
  localparam logic [HW-1:0] HOLD_LAST  = HW'(HOLD_TICKS - 1);
  localparam logic [DW-1:0] DUMMY_LAST = DW'(DUMMY_RUNS - 1);

  sq_state_t     state_q, state_d;
  logic [RW-1:0] ramp_q, ramp_d;
  logic [HW-1:0] hold_q, hold_d;
  logic [DW-1:0] dummy_q, dummy_d;
  logic          upd;

  assign upd = tick | ~en;

  always_comb begin
    state_d = state_q;
    ramp_d  = ramp_q;
    hold_d  = hold_q;
    dummy_d = dummy_q;
    if (!en) begin
      state_d = SQ_OFF;
      ramp_d  = '0;
      hold_d  = '0;
      dummy_d = '0;
    end else begin
      case (state_q)
        SQ_OFF: begin
          state_d = SQ_RAMP;
          ramp_d  = '0;
        end
        SQ_RAMP, SQ_RUN: begin
          if (ov_fire) begin
            state_d = SQ_OV_WAIT;
            ramp_d  = '0;
          end else if (oc_trip) begin
            state_d = SQ_OC_HOLD;
            ramp_d  = '0;
            hold_d  = '0;
          end else if (state_q == SQ_RAMP) begin
            if (ramp_q == RAMP_LAST) state_d = SQ_RUN;
            else                     ramp_d  = ramp_q + 1'b1;
          end
        end
        SQ_OC_HOLD: begin
          if (hold_q == HOLD_LAST) begin
            state_d = SQ_RAMP;
            ramp_d  = '0;
          end else begin
            hold_d = hold_q + 1'b1;
          end
        end
        SQ_OV_WAIT: begin
          if (uv) begin
            state_d = SQ_OV_DUMMY;
            ramp_d  = '0;
            dummy_d = '0;
          end
        end
        SQ_OV_DUMMY: begin
          if (ramp_q == RAMP_LAST) begin
            ramp_d = '0;
            if (dummy_q == DUMMY_LAST) state_d = SQ_RAMP;
            else                       dummy_d = dummy_q + 1'b1;
          end else begin
            ramp_d = ramp_q + 1'b1;
          end
        end
        default: state_d = SQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_OFF;
      ramp_q  <= '0;
      hold_q  <= '0;
      dummy_q <= '0;
    end else if (upd) begin
      state_q <= state_d;
      ramp_q  <= ramp_d;
      hold_q  <= hold_d;
      dummy_q <= dummy_d;
    end
  end

  assign pwm_en    = (state_q == SQ_RAMP) | (state_q == SQ_RUN);
  assign ss_active = (state_q == SQ_RAMP);
  assign ramp      = pwm_en ? ramp_q : '0;
endmodule

// File: rtl/ss_fault_seq.sv
module ss_fault_seq #(
  parameter int SS_CYCLES     = 4096,
  parameter int OC_ACC_W      = 4,
  parameter int OC_STEP_UP    = 2,
  parameter int OC_STEP_DN    = 1,
  parameter int OC_HOLD_TICKS = 16,
  parameter int OV_PERSIST    = 32,
  parameter int DUMMY_RUNS    = 2,
  localparam int RW = $clog2(SS_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_tick,
  input  logic          en,
  input  logic          oc_sample,
  input  logic          ov_flag,
  input  logic          uv_flag,
  output logic          pwm_en,
  output logic          ss_active,
  output logic [RW-1:0] ss_ramp
);
  logic step, clr, oc_trip, ov_fire;

  // Fault counters only advance on ticks while switching; emptied otherwise.
  assign step = cyc_tick & en & pwm_en;
  assign clr  = ~en | ~pwm_en;

  ssf_oc_acc #(.ACC_W(OC_ACC_W), .UP(OC_STEP_UP), .DN(OC_STEP_DN)) u_oc (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(clr),
    .hit(oc_sample), .trip(oc_trip)
  );

  ssf_persist #(.LEN(OV_PERSIST)) u_ov (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(clr),
    .flag(ov_flag), .fire(ov_fire)
  );

  ssf_seq #(.SS_CYCLES(SS_CYCLES), .HOLD_TICKS(OC_HOLD_TICKS),
            .DUMMY_RUNS(DUMMY_RUNS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .en(en),
    .oc_trip(oc_trip), .ov_fire(ov_fire), .uv(uv_flag),
    .pwm_en(pwm_en), .ss_active(ss_active), .ramp(ss_ramp)
  );
endmodule

// File: rtl/ssf_checker.sv
module ssf_checker #(
  parameter int SS_CYCLES = 4096,
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          cyc_tick,
  input logic          pwm_en,
  input logic          ss_active,
  input logic [RW-1:0] ss_ramp
);
  AST_OFF_AFTER_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_en && !ss_active && ss_ramp == '0)); // R1

  AST_RAMP_NEEDS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active |-> pwm_en); // R2

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> (ss_active && ss_ramp == '0)); // R7

  AST_RUN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !ss_active) |-> ss_ramp == RW'(SS_CYCLES - 1)); // R3

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cyc_tick) |=> ($stable(pwm_en) && $stable(ss_active) && $stable(ss_ramp))); // R4

  AST_IDLE_RAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |-> (ss_ramp == '0 && !ss_active)); // R13
endmodule

bind ss_fault_seq ssf_checker #(.SS_CYCLES(SS_CYCLES), .RW(RW)) u_ssf_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cyc_tick(cyc_tick),
  .pwm_en(pwm_en), .ss_active(ss_active), .ss_ramp(ss_ramp)
);

// File: tb/tb_ss_fault_seq.sv
`timescale 1ns/1ps
module tb_ss_fault_seq;
  localparam int SSN = 4096;

  logic clk = 1'b0;
  logic rst_n, cyc_tick, en, oc_sample, ov_flag, uv_flag;
  logic pwm_en, ss_active;
  logic [11:0] ss_ramp;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  ss_fault_seq dut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .en(en),
    .oc_sample(oc_sample), .ov_flag(ov_flag), .uv_flag(uv_flag),
    .pwm_en(pwm_en), .ss_active(ss_active), .ss_ramp(ss_ramp)
  );

  // Behavioural reference model
  localparam int M_OFF = 0, M_SOFT = 1, M_RUN = 2, M_OCW = 3, M_OVW = 4, M_DUM = 5;
  int m_mode = M_OFF, m_ramp = 0, m_acc = 0, m_ovc = 0, m_wait = 0, m_dum = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = M_OFF; m_ramp = 0; m_acc = 0; m_ovc = 0; m_wait = 0; m_dum = 0;
    end else if (!en) begin
      m_mode = M_OFF; m_ramp = 0;
    end else if (cyc_tick) begin
      case (m_mode)
        M_OFF: begin m_mode = M_SOFT; m_ramp = 0; end
        M_SOFT, M_RUN: begin
          int nacc;
          nacc = oc_sample ? ((m_acc + 2 > 15) ? 15 : m_acc + 2)
                           : ((m_acc > 0) ? m_acc - 1 : 0);
          if (ov_flag && m_ovc + 1 >= 32) begin
            m_mode = M_OVW; m_ramp = 0;
          end else if (nacc == 15) begin
            m_mode = M_OCW; m_ramp = 0; m_wait = 0;
          end else begin
            m_acc = nacc;
            m_ovc = ov_flag ? m_ovc + 1 : 0;
            if (m_mode == M_SOFT) begin
              if (m_ramp == SSN - 1) m_mode = M_RUN;
              else m_ramp++;
            end
          end
        end
        M_OCW: begin
          if (m_wait == 15) begin m_mode = M_SOFT; m_ramp = 0; end
          else m_wait++;
        end
        M_OVW: if (uv_flag) begin m_mode = M_DUM; m_ramp = 0; m_dum = 0; end
        M_DUM: begin
          if (m_ramp == SSN - 1) begin
            m_ramp = 0;
            if (m_dum == 1) m_mode = M_SOFT; else m_dum++;
          end else m_ramp++;
        end
        default: m_mode = M_OFF;
      endcase
    end
    if (m_mode != M_SOFT && m_mode != M_RUN) begin m_acc = 0; m_ovc = 0; end
  end

  function automatic int exp_pwm();
    return (m_mode == M_SOFT || m_mode == M_RUN) ? 1 : 0;
  endfunction

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    int er;
    er = exp_pwm() ? m_ramp : 0;
    checks++;
    if (pwm_en !== 1'(exp_pwm()) || ss_active !== 1'(m_mode == M_SOFT) ||
        ss_ramp !== 12'(er)) begin
      failures++;
      $display("FAIL %s model: pwm=%0d ss=%0d ramp=%0d expected pwm=%0d ss=%0d ramp=%0d",
               cur_req, pwm_en, ss_active, ss_ramp, exp_pwm(), (m_mode == M_SOFT), er);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One tick with the given flags, followed by gap idle clocks
  task automatic tk(input logic oc, input logic ov, input logic uv, input int gap);
    cyc_tick = 1'b1; oc_sample = oc; ov_flag = ov; uv_flag = uv;
    @(negedge clk);
    cyc_tick = 1'b0; oc_sample = 1'b0; ov_flag = 1'b0; uv_flag = 1'b0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) tk(1'b0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_tick = 1'b0; en = 1'b0;
    oc_sample = 1'b0; ov_flag = 1'b0; uv_flag = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 reset pwm", pwm_en, 0);
    chk("R1 reset ramp", ss_ramp, 0);
    rst_n = 1'b1;
    clean(5);
    chk("R1 en low pwm", pwm_en, 0);

    cur_req = "R2"; en = 1'b1;
    tk(1'b0, 1'b0, 1'b0, 0);
    chk("R2 start ss_active", ss_active, 1);
    chk("R2 start ramp", ss_ramp, 0);
    clean(10);
    chk("R2 ramp count", ss_ramp, 10);

    cur_req = "R4";
    repeat (6) @(negedge clk);
    chk("R4 frozen ramp", ss_ramp, 10);
    tk(1'b0, 1'b0, 1'b0, 2);
    chk("R4 sparse tick", ss_ramp, 11);

    cur_req = "R3";
    clean(SSN - 12);
    chk("R3 last ramp step", ss_active, 1);
    clean(1);
    chk("R3 ss_active low", ss_active, 0);
    chk("R3 pwm on", pwm_en, 1);
    chk("R3 ramp top", ss_ramp, SSN - 1);

    cur_req = "R5";
    for (int i = 0; i < 60; i++) tk((i % 3) == 0, 1'b0, 1'b0, 0);
    chk("R5 one-in-three holds", pwm_en, 1);
    cur_req = "R6";
    clean(20);
    for (int i = 0; i < 7; i++) tk(1'b1, 1'b0, 1'b0, 0);
    chk("R6 seven hits no trip", pwm_en, 1);
    cur_req = "R5";
    tk(1'b1, 1'b0, 1'b0, 0);
    chk("R5 eighth hit trips", pwm_en, 0);

    cur_req = "R7";
    clean(15);
    chk("R7 hold 15", pwm_en, 0);
    clean(1);
    chk("R7 restart pwm", pwm_en, 1);
    chk("R7 restart ramp", ss_ramp, 0);

    cur_req = "R8";
    for (int i = 0; i < 7; i++) tk(1'b1, 1'b0, 1'b0, 0);
    chk("R8 acc empty at restart", pwm_en, 1);
    clean(20);

    cur_req = "R9";
    for (int i = 0; i < 31; i++) tk(1'b0, 1'b1, 1'b0, 0);
    clean(1);
    for (int i = 0; i < 31; i++) tk(1'b0, 1'b1, 1'b0, 0);
    chk("R9 broken runs no trip", pwm_en, 1);
    clean(1);

    cur_req = "R12";
    for (int i = 0; i < 24; i++) tk((i % 3) == 0, 1'b1, 1'b0, 0);
    for (int i = 0; i < 7; i++) tk(1'b1, 1'b1, 1'b0, 0);
    chk("R12 before joint trip", pwm_en, 1);
    tk(1'b1, 1'b1, 1'b0, 0);
    chk("R9 32nd ov trips", pwm_en, 0);

    cur_req = "R10";
    clean(100);
    chk("R10 waits for uv", pwm_en, 0);
    chk("R12 no oc restart", ss_active, 0);

    cur_req = "R11";
    tk(1'b0, 1'b0, 1'b1, 0);
    for (int i = 0; i < 2 * SSN - 1; i++) tk(1'b0, 1'b0, 1'b0, 1);
    chk("R11 idle periods", pwm_en, 0);
    tk(1'b0, 1'b0, 1'b0, 1);
    chk("R11 restart pwm", pwm_en, 1);
    chk("R11 restart ramp", ss_ramp, 0);

    cur_req = "R13";
    clean(40);
    en = 1'b0;
    @(negedge clk);
    chk("R13 en low off", pwm_en, 0);
    chk("R13 en low ramp", ss_ramp, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R13 waits tick", pwm_en, 0);
    tk(1'b0, 1'b0, 1'b0, 0);
    chk("R13 fresh start", ss_active, 1);
    chk("R13 fresh ramp", ss_ramp, 0);
    clean(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule